// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the shared control and status register file for an eight-channel DMA engine. Software reaches it through a plain word-wide write port and a combinational read path. Each of its four registers sits at a 16-byte base address. The three words that follow each base are alias addresses:

- a write at base + 0x4 ORs the written bits in;
- a write at base + 0x8 clears the written bits;
- a write at base + 0xC flips the written bits.

With these aliases, software can change single per-channel bits without a read-modify-write sequence.

The registers are laid out as follows:

| Register | Base | Contents |
|----------|------|----------|
| Control | 0x00 | per-channel clock gates, wide-burst enable, peripheral-burst enable |
| Interrupt | 0x10 | per-channel completion status, per-channel interrupt enables |
| Error | 0x20 | per-channel error status |
| Channel control | 0x30 | per-channel freeze field, per-channel self-clearing reset field |

The channels raise single-cycle completion and error events, and those events set the status bits. A channel is pending while either of its status bits is set. Software acknowledges a channel by writing the channel's bit to the clear alias of both status registers. The block drives one combined interrupt line.

The port has no back-pressure. Every write completes in the cycle it is presented, so no handshake is needed. Reads are combinational on the address.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write with `addr[3:2]`=0 to a register base replaces the register's implemented bits with the written data; unimplemented bits always read as zero.
- R2: A write with `addr[3:2]`=1 ORs the written bits into the selected register and leaves every other bit unchanged.
- R3: A write with `addr[3:2]`=2 clears the written bits in the selected register and leaves every other bit unchanged.
- R4: A write with `addr[3:2]`=3 inverts the written bits in the selected register and leaves every other bit unchanged.
- R5: After reset all eight clock-gate bits read as one and every other bit reads as zero.
- R6: Control register `addr[5:4]`=0 holds clock gates at bits 15:8 (bit 8+i for channel i), the wide-burst enable at bit 31 and the peripheral-burst enable at bit 30. These drive `clk_gate`, `burst8_en` and `pburst_en`.
- R7: Interrupt register `addr[5:4]`=1 holds completion status at bit i, set by `done_evt[i]`, and the interrupt enable at bit 16+i. Error register `addr[5:4]`=2 holds error status at bit i, set by `err_evt[i]`.
- R8: When a status event and a software clear or overwrite of the same bit occur in the same cycle, the bit ends up set.
- R9: `chan_pending[i]` is the OR of completion and error status of channel i; writing bit i to the clear alias of both status registers acknowledges the channel.
- R10: `irq` is high exactly when some channel has completion status and its enable both set, or has error status set.
- R11: Channel-control register `addr[5:4]`=3 holds reset bits at 23:16. A base, set or toggle write with bit 16+i set produces a one-cycle `ch_reset[i]` pulse in the cycle after the write, and the reset field always reads as zero.
- R12: Channel-control bits 7:0 are the freeze bits and drive `freeze`.
- R13: A write whose address has any bit above bit 5 set, or either of bits 1:0 set, changes no register, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 8 | Byte address: register in bits 5:4, alias in bits 3:2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (aliases read the base register) |
| done_evt | input | 8 | Per-channel completion events |
| err_evt | input | 8 | Per-channel error events |
| clk_gate | output | 8 | Per-channel clock-gate controls |
| burst8_en | output | 1 | Wide-burst enable |
| pburst_en | output | 1 | Peripheral-burst enable |
| freeze | output | 8 | Per-channel freeze controls |
| ch_reset | output | 8 | Per-channel one-cycle reset pulses |
| chan_pending | output | 8 | Per-channel pending flags |
| irq | output | 1 | Combined interrupt |

## Verification
The following properties are checked on every cycle:

- a status event always leaves its channel pending on the next cycle, whatever software wrote;
- an error event always raises the interrupt;
- a reset pulse never lasts beyond one cycle without a fresh write;
- a write to an unmapped address leaves every output unchanged.

The bench's scenarios are needed for the exact bit results of each alias operation, the layout of every field, the reset values, the acknowledge sequence and the enable-gated interrupt. Those results are compared against a bench-side model under random and directed writes.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  localparam int NREG      = 4;
  localparam int REG_CTRL  = 0;
  localparam int REG_IRQ   = 1;
  localparam int REG_ERR   = 2;
  localparam int REG_CHCTL = 3;

  localparam int GATE_LSB  = 8;
  localparam int IEN_LSB   = 16;
  localparam int RST_LSB   = 16;
  localparam int B8_BIT    = 31;
  localparam int PB_BIT    = 30;
  localparam int MAP_BITS  = 6;
endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
  import dmacr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [1:0]    reg_sel,
  output alias_op_e     op,
  output logic [NREG-1:0] wr_sel
);
  localparam int HI_W = AW - MAP_BITS;

  always_comb begin
    hit     = (addr[AW-1:MAP_BITS] == HI_W'(0)) && (addr[1:0] == 2'b00);
    reg_sel = addr[5:4];
    op      = alias_op_e'(addr[3:2]);
    for (int i = 0; i < NREG; i++) begin
      wr_sel[i] = wr_en && hit && (reg_sel == 2'(i));
    end
  end
endmodule

// File: rtl/dmacr_bitop.sv
module dmacr_bitop
  import dmacr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] wdata,
  input  alias_op_e     op,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] nxt
);
  logic [DW-1:0] raw;

  always_comb begin
    unique case (op)
      OP_WRITE: raw = wdata;
      OP_SET:   raw = cur | wdata;
      OP_CLR:   raw = cur & ~wdata;
      default:  raw = cur ^ wdata;
    endcase
    nxt = raw & mask;
  end
endmodule

// File: rtl/dmacr_reg.sv
module dmacr_reg #(
  parameter int              DW        = 32,
  parameter logic [DW-1:0]   RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] nxt,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] q
);
  // Hardware set events are ORed after the software update, so they win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= (we ? nxt : q) | set_bits;
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dmacr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] done_evt,
  input  logic [NCH-1:0] err_evt,
  output logic [NCH-1:0] clk_gate,
  output logic           burst8_en,
  output logic           pburst_en,
  output logic [NCH-1:0] freeze,
  output logic [NCH-1:0] ch_reset,
  output logic [NCH-1:0] chan_pending,
  output logic           irq
);
  localparam logic [DW-1:0] CH_ONES    = DW'((64'd1 << NCH) - 64'd1);
  localparam logic [DW-1:0] GATE_FIELD = CH_ONES << GATE_LSB;
  localparam logic [DW-1:0] CTRL_MASK  = GATE_FIELD | (DW'(1) << B8_BIT) | (DW'(1) << PB_BIT);
  localparam logic [DW-1:0] IRQ_MASK   = CH_ONES | (CH_ONES << IEN_LSB);
  localparam logic [DW-1:0] ERR_MASK   = CH_ONES;
  localparam logic [DW-1:0] CHCTL_MASK = CH_ONES;

  function automatic logic [DW-1:0] reg_mask(input int idx);
    case (idx)
      REG_CTRL: return CTRL_MASK;
      REG_IRQ:  return IRQ_MASK;
      REG_ERR:  return ERR_MASK;
      default:  return CHCTL_MASK;
    endcase
  endfunction

  logic            hit;
  logic [1:0]      reg_sel;
  alias_op_e       op;
  logic [NREG-1:0] wr_sel;
  logic [DW-1:0]   q   [NREG];
  logic [DW-1:0]   nxt [NREG];
  logic [DW-1:0]   setb[NREG];
  logic [NCH-1:0]  rst_q;

  dmacr_decode #(.AW(AW)) dec_i (
    .wr_en(wr_en), .addr(addr), .hit(hit), .reg_sel(reg_sel), .op(op), .wr_sel(wr_sel)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) setb[i] = '0;
    setb[REG_IRQ] = DW'(done_evt);
    setb[REG_ERR] = DW'(err_evt);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    dmacr_bitop #(.DW(DW)) op_i (
      .cur(q[g]), .wdata(wdata), .op(op), .mask(reg_mask(g)), .nxt(nxt[g])
    );
    dmacr_reg #(.DW(DW), .RESET_VAL((g == REG_CTRL) ? GATE_FIELD : '0)) reg_i (
      .clk(clk), .rst_n(rst_n), .we(wr_sel[g]), .nxt(nxt[g]), .set_bits(setb[g]), .q(q[g])
    );
  end

  // Reset field is not stored: a write produces a single-cycle pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rst_q <= '0;
    else if (wr_sel[REG_CHCTL]) rst_q <= (op != OP_CLR) ? wdata[RST_LSB +: NCH] : '0;
    else                       rst_q <= '0;
  end

  always_comb begin
    rdata        = hit ? q[reg_sel] : '0;
    clk_gate     = q[REG_CTRL][GATE_LSB +: NCH];
    burst8_en    = q[REG_CTRL][B8_BIT];
    pburst_en    = q[REG_CTRL][PB_BIT];
    freeze       = q[REG_CHCTL][NCH-1:0];
    ch_reset     = rst_q;
    chan_pending = q[REG_IRQ][NCH-1:0] | q[REG_ERR][NCH-1:0];
    irq          = |((q[REG_IRQ][NCH-1:0] & q[REG_IRQ][IEN_LSB +: NCH]) | q[REG_ERR][NCH-1:0]);
  end
endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk #(
  parameter int NCH = 8,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [NCH-1:0] done_evt,
  input logic [NCH-1:0] err_evt,
  input logic [NCH-1:0] clk_gate,
  input logic           burst8_en,
  input logic [NCH-1:0] freeze,
  input logic [NCH-1:0] ch_reset,
  input logic [NCH-1:0] chan_pending,
  input logic           irq
);
  logic unmapped;
  assign unmapped = ((addr >> 6) != '0) || (addr[1:0] != 2'b00);

  // R8: an event leaves its channel pending whatever software wrote
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_evt | err_evt)) |=> ((chan_pending & $past(done_evt | err_evt)) == $past(done_evt | err_evt)));

  // R10: an error event raises the interrupt
  a_r10_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> irq);

  // R11: a reset pulse lasts one cycle without a fresh write
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ch_reset) && !wr_en) |=> (ch_reset == '0));

  // R13: writes to unmapped addresses change nothing
  a_r13_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped && !(|done_evt) && !(|err_evt)) |=>
      ($stable(clk_gate) && $stable(freeze) && $stable(chan_pending) && $stable(burst8_en) && ch_reset == '0));
endmodule

bind dma_ctl_regs dmacr_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .done_evt(done_evt),
  .err_evt(err_evt), .clk_gate(clk_gate), .burst8_en(burst8_en), .freeze(freeze),
  .ch_reset(ch_reset), .chan_pending(chan_pending), .irq(irq)
);

// File: tb/dma_ctl_regs_tb_top.sv
module dma_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  done_evt = '0, err_evt = '0;
  logic [7:0]  clk_gate, freeze, ch_reset, chan_pending;
  logic        burst8_en, pburst_en, irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench model of register contents
  logic [31:0] m_ctrl, m_irq, m_err, m_chctl;
  logic [7:0]  m_rst;

  always #10 clk = ~clk;

  dma_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .done_evt(done_evt), .err_evt(err_evt), .clk_gate(clk_gate), .burst8_en(burst8_en),
    .pburst_en(pburst_en), .freeze(freeze), .ch_reset(ch_reset),
    .chan_pending(chan_pending), .irq(irq)
  );

  function automatic logic [31:0] alias_calc(logic [31:0] cur, logic [31:0] d, logic [1:0] o);
    case (o)
      2'd0: return d;
      2'd1: return cur | d;
      2'd2: return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_chk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic check_all();
    logic [7:0] saved;
    saved = addr;
    chk("R6 clk_gate", 32'(clk_gate), 32'(m_ctrl[15:8]));
    chk("R6 burst", {30'd0, burst8_en, pburst_en}, {30'd0, m_ctrl[31], m_ctrl[30]});
    chk("R12 freeze", 32'(freeze), 32'(m_chctl[7:0]));
    chk("R11 ch_reset", 32'(ch_reset), 32'(m_rst));
    chk("R9 pending", 32'(chan_pending), 32'(m_irq[7:0] | m_err[7:0]));
    chk("R10 irq", 32'(irq), 32'(|((m_irq[7:0] & m_irq[23:16]) | m_err[7:0])));
    read_chk("R1 ctrl read", 8'h00, m_ctrl);
    read_chk("R7 irq read", 8'h14, m_irq);
    read_chk("R7 err read", 8'h28, m_err);
    read_chk("R11 chctl read", 8'h3C, m_chctl);
    read_chk("R13 unmapped read", 8'h50, 32'd0);
    addr = saved;
  endtask

  // One bus cycle; the model is updated from the requirements after the edge.
  task automatic cyc(logic we, logic [7:0] a, logic [31:0] d, logic [7:0] de, logic [7:0] ee);
    logic mapped;
    logic [1:0] o;
    wr_en = we; addr = a; wdata = d; done_evt = de; err_evt = ee;
    @(posedge clk);
    mapped = (a[7:6] == 2'b00) && (a[1:0] == 2'b00);
    o = a[3:2];
    m_rst = '0;
    if (we && mapped) begin
      case (a[5:4])
        2'd0: m_ctrl  = alias_calc(m_ctrl, d, o) & 32'hC000_FF00;
        2'd1: m_irq   = alias_calc(m_irq, d, o)  & 32'h00FF_00FF;
        2'd2: m_err   = alias_calc(m_err, d, o)  & 32'h0000_00FF;
        default: begin
          m_chctl = alias_calc(m_chctl, d, o) & 32'h0000_00FF;
          m_rst   = alias_calc(32'd0, d, o) >> 16;
        end
      endcase
    end
    m_irq[7:0] = m_irq[7:0] | de;
    m_err[7:0] = m_err[7:0] | ee;
    @(negedge clk);
    wr_en = 1'b0; done_evt = '0; err_evt = '0;
    check_all();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ctrl = 32'h0000_FF00; m_irq = '0; m_err = '0; m_chctl = '0; m_rst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset values
    check_all();
    // R1 base write, R2 set, R3 clear, R4 toggle on control register
    cyc(1, 8'h00, 32'hFFFF_FFFF, 0, 0);
    cyc(1, 8'h08, 32'h8000_0F00, 0, 0);
    cyc(1, 8'h04, 32'h8000_0100, 0, 0);
    cyc(1, 8'h0C, 32'h4000_00FF, 0, 0);
    // R7/R10: enable completion interrupts for channels 0 and 2
    cyc(1, 8'h14, 32'h0005_0000, 0, 0);
    cyc(0, 8'h00, 0, 8'h02, 0);
    cyc(0, 8'h00, 0, 8'h04, 0);
    // R8: clear and event on the same bit in one cycle
    cyc(1, 8'h18, 32'h0000_0004, 8'h04, 0);
    cyc(1, 8'h10, 32'h0005_0000, 0, 8'h10);
    // R9: acknowledge channels through both clear aliases
    cyc(1, 8'h18, 32'h0000_00FF, 0, 0);
    cyc(1, 8'h28, 32'h0000_00FF, 0, 0);
    // R11: reset pulse then drop; clear alias gives no pulse
    cyc(1, 8'h34, 32'h0003_0081, 0, 0);
    cyc(0, 8'h00, 0, 0, 0);
    cyc(1, 8'h38, 32'h00FF_0001, 0, 0);
    // R13: unmapped and unaligned writes
    cyc(1, 8'h40, 32'hFFFF_FFFF, 0, 0);
    cyc(1, 8'h01, 32'hFFFF_FFFF, 0, 0);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      a = {2'b00, 6'($urandom) & 6'h3C};
      if ($urandom % 10 == 0) a = 8'($urandom);
      cyc(1'($urandom % 4 != 0), a, $urandom,
          ($urandom % 3 == 0) ? 8'($urandom) : 8'h00,
          ($urandom % 5 == 0) ? 8'($urandom) : 8'h00);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule